// File: doc/BRIEF.md
# Low-Power Mode Clock Gating Controller

This block holds the power mode of a small processor subsystem. It turns that mode into one enable per clock domain or oscillator control. There is one active mode and five sleep depths. Each deeper depth switches off a larger set of functions: first the CPU clock, then the frequency-lock loop control, then the main and sub-main clocks with the DCO clock, then the DCO dc generator, and last the auxiliary clock and the crystal oscillator.

Software selects a mode with a write strobe. When an interrupt is pending, the block saves the current mode and forces active mode so that the request can be serviced. The return-from-interrupt strobe then restores the saved mode. A write made while an interrupt is being serviced changes the mode that the return will restore, so a service routine can keep the system awake or put it to sleep on exit. Every enable comes from a flop, so enables change only at a clock edge.

Top module: `pmg_top`

## Requirements
- R1: While reset is high and in the cycle after it, all eight enables are 1 (active mode), and no interrupt is in service.
- R2: Mode encodings: 0 is active mode, 1 is LPM0 and 2 is LPM1. Active mode enables everything. LPM0 turns off only `cpu_clk_en`. LPM1 turns off `cpu_clk_en` and `fll_en`. A write outside service takes effect at the clock edge that samples `mode_wr`.
- R3: Encoding 3 (LPM2) turns off `cpu_clk_en`, `fll_en`, `mclk_en`, `smclk_en` and `dco_clk_en`, and keeps `dco_dc_en`, `aclk_en` and `xtal_en` on. Encoding 4 (LPM3) also turns off `dco_dc_en`.
- R4: Encoding 5 (LPM4) turns off all eight enables.
- R5: Encodings 6 and 7 give exactly the LPM4 enables.
- R6: When `irq_pend` is sampled high and no interrupt is in service, all enables, including `cpu_clk_en`, are 1 after that same edge. The mode in force is saved and service begins. This applies in every mode, including active mode.
- R7: When `reti_stb` is sampled high during service, the saved mode's enables appear at that edge and service ends.
- R8: `reti_stb` outside service has no effect.
- R9: `irq_pend` during service has no effect. The saved mode is not overwritten, and all enables stay 1.
- R10: A write during service leaves all enables at 1 and replaces the saved mode (normalized as in R5). The return then restores the new mode.
- R11: A write in the same cycle as an accepted wake (R6) or an accepted return (R7) is dropped.
- R12: With no accepted wake, return or write, all enables hold their values. The enables are nested: `aclk_en` low implies `dco_dc_en` low, `dco_dc_en` low implies `dco_clk_en` low, `dco_clk_en` low implies `fll_en` low, and `fll_en` low implies `cpu_clk_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Software mode write strobe |
| mode_wdata | input | MODE_W (3) | Mode encoding to write |
| irq_pend | input | 1 | Interrupt pending |
| reti_stb | input | 1 | Return-from-interrupt strobe |
| cpu_clk_en | output | 1 | CPU clock enable |
| mclk_en | output | 1 | Main clock enable |
| smclk_en | output | 1 | Sub-main clock enable |
| aclk_en | output | 1 | Auxiliary clock enable |
| fll_en | output | 1 | Frequency-lock loop control enable |
| dco_clk_en | output | 1 | DCO clock enable |
| dco_dc_en | output | 1 | DCO dc generator enable |
| xtal_en | output | 1 | Crystal oscillator enable |

## Verification
The bench builds the block with its defaults: a 3-bit mode field and five sleep depths. With these values all eight encodings can be swept, including the two that fold onto the deepest mode. For every starting mode it crosses every mode written during service. This brings each save, restore and replaced-restore path within reach, as well as the dropped writes that coincide with a wake or a return. Expected enables come from each enable's switch-off depth, compared against the normalized mode.

// File: rtl/pmg_pkg.sv
package pmg_pkg;

    localparam int PMG_MODE_W  = 3;
    localparam int PMG_DEEPEST = 5;
    localparam int PMG_EN_N    = 8;

    // Index of each enable in the internal enable vector
    typedef enum int {
        EN_CPU    = 0,
        EN_FLL    = 1,
        EN_MCLK   = 2,
        EN_SMCLK  = 3,
        EN_DCOCLK = 4,
        EN_DCODC  = 5,
        EN_ACLK   = 6,
        EN_XTAL   = 7
    } pmg_en_idx_e;

    // First mode value (0 = active) at which the enable is switched off
    function automatic int pmg_off_level(input int idx);
        case (idx)
            EN_CPU:    return 1;
            EN_FLL:    return 2;
            EN_MCLK,
            EN_SMCLK,
            EN_DCOCLK: return 3;
            EN_DCODC:  return 4;
            default:   return 5;
        endcase
    endfunction

endpackage

// File: rtl/pmg_mode_ctrl.sv
module pmg_mode_ctrl
    import pmg_pkg::*;
#(
    parameter int MODE_W  = PMG_MODE_W,
    parameter int DEEPEST = PMG_DEEPEST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [MODE_W-1:0] wdata,
    input  logic              irq,
    input  logic              reti,
    output logic [MODE_W-1:0] nx_mode,
    output logic              busy
);

    localparam logic [MODE_W-1:0] MODE_ACTIVE = '0;
    localparam logic [MODE_W-1:0] MODE_MAX    = MODE_W'(DEEPEST);

    logic [MODE_W-1:0] run_q, saved_q, saved_d, wnorm;
    logic              busy_d;

    assign wnorm = (wdata > MODE_MAX) ? MODE_MAX : wdata;

    always_comb begin
        nx_mode = run_q;
        saved_d = saved_q;
        busy_d  = busy;
        if (busy) begin
            if (reti) begin
                nx_mode = saved_q;
                busy_d  = 1'b0;
            end else if (wr) begin
                saved_d = wnorm;
            end
        end else begin
            if (irq) begin
                saved_d = run_q;
                nx_mode = MODE_ACTIVE;
                busy_d  = 1'b1;
            end else if (wr) begin
                nx_mode = wnorm;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= MODE_ACTIVE;
            saved_q <= MODE_ACTIVE;
            busy    <= 1'b0;
        end else begin
            run_q   <= nx_mode;
            saved_q <= saved_d;
            busy    <= busy_d;
        end
    end

    // R7: an accepted return reinstates the mode held before it
    p_restore_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && reti) |=> (run_q == $past(saved_q)));

    // R5: the mode in force never exceeds the deepest depth
    p_norm_r5: assert property (@(posedge clk) disable iff (rst)
        (run_q <= MODE_MAX) && (saved_q <= MODE_MAX));

    // R9: a second interrupt during service leaves the saved mode alone
    p_nonest_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && irq && !reti && !wr) |=> $stable(saved_q));

endmodule

// File: rtl/pmg_gate_bank.sv
module pmg_gate_bank
    import pmg_pkg::*;
#(
    parameter int MODE_W = PMG_MODE_W,
    parameter int EN_N   = PMG_EN_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] nx_mode,
    output logic [EN_N-1:0]   en
);

    for (genvar i = 0; i < EN_N; i++) begin : g_en
        logic on_d;
        assign on_d = (int'(nx_mode) < pmg_off_level(i));
        always_ff @(posedge clk) begin
            if (rst) en[i] <= 1'b1;
            else     en[i] <= on_d;
        end
    end

    // R12: enables switch off in nested order
    p_nest_aclk_r12: assert property (@(posedge clk) disable iff (rst)
        !en[EN_ACLK] |-> !en[EN_DCODC]);
    p_nest_dc_r12: assert property (@(posedge clk) disable iff (rst)
        !en[EN_DCODC] |-> !en[EN_DCOCLK]);
    p_nest_dco_r12: assert property (@(posedge clk) disable iff (rst)
        !en[EN_DCOCLK] |-> !en[EN_FLL]);
    p_nest_fll_r12: assert property (@(posedge clk) disable iff (rst)
        !en[EN_FLL] |-> !en[EN_CPU]);

endmodule

// File: rtl/pmg_top.sv
module pmg_top
    import pmg_pkg::*;
#(
    parameter int MODE_W  = PMG_MODE_W,
    parameter int DEEPEST = PMG_DEEPEST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              irq_pend,
    input  logic              reti_stb,
    output logic              cpu_clk_en,
    output logic              mclk_en,
    output logic              smclk_en,
    output logic              aclk_en,
    output logic              fll_en,
    output logic              dco_clk_en,
    output logic              dco_dc_en,
    output logic              xtal_en
);

    localparam int EN_N = PMG_EN_N;

    logic [MODE_W-1:0] nx_mode;
    logic              busy;
    logic [EN_N-1:0]   en;

    pmg_mode_ctrl #(.MODE_W(MODE_W), .DEEPEST(DEEPEST)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr      (mode_wr),
        .wdata   (mode_wdata),
        .irq     (irq_pend),
        .reti    (reti_stb),
        .nx_mode (nx_mode),
        .busy    (busy)
    );

    pmg_gate_bank #(.MODE_W(MODE_W), .EN_N(EN_N)) u_gate (
        .clk     (clk),
        .rst     (rst),
        .nx_mode (nx_mode),
        .en      (en)
    );

    assign cpu_clk_en = en[EN_CPU];
    assign fll_en     = en[EN_FLL];
    assign mclk_en    = en[EN_MCLK];
    assign smclk_en   = en[EN_SMCLK];
    assign dco_clk_en = en[EN_DCOCLK];
    assign dco_dc_en  = en[EN_DCODC];
    assign aclk_en    = en[EN_ACLK];
    assign xtal_en    = en[EN_XTAL];

    // R6: an accepted wake gives a running CPU right after the sampling edge
    p_wake_r6: assert property (@(posedge clk) disable iff (rst)
        (irq_pend && !busy) |=> (cpu_clk_en && (&en)));

    // R9: everything runs while an interrupt is in service
    p_service_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (&en));

    // R12: enables hold without an accepted event
    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!(irq_pend && !busy) && !(reti_stb && busy) && !mode_wr) |=> $stable(en));

endmodule

// File: tb/tb_pmg_top.sv
module tb_pmg_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       mode_wr;
    logic [2:0] mode_wdata;
    logic       irq_pend;
    logic       reti_stb;
    logic       cpu_clk_en, mclk_en, smclk_en, aclk_en;
    logic       fll_en, dco_clk_en, dco_dc_en, xtal_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pmg_top dut (
        .clk        (clk),
        .rst        (rst),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .irq_pend   (irq_pend),
        .reti_stb   (reti_stb),
        .cpu_clk_en (cpu_clk_en),
        .mclk_en    (mclk_en),
        .smclk_en   (smclk_en),
        .aclk_en    (aclk_en),
        .fll_en     (fll_en),
        .dco_clk_en (dco_clk_en),
        .dco_dc_en  (dco_dc_en),
        .xtal_en    (xtal_en)
    );

    // bit order: xtal aclk dcodc dcoclk smclk mclk fll cpu
    logic [7:0] got;
    assign got = {xtal_en, aclk_en, dco_dc_en, dco_clk_en,
                  smclk_en, mclk_en, fll_en, cpu_clk_en};

    function automatic logic [7:0] expect_en(input int m);
        int nm;
        int thr [8];
        logic [7:0] r;
        nm = (m > 5) ? 5 : m;
        thr = '{1, 2, 3, 3, 3, 4, 5, 5};
        for (int i = 0; i < 8; i++) r[i] = (nm < thr[i]);
        return r;
    endfunction

    function automatic string req_of(input int m);
        if (m <= 2) return "R2";
        if (m <= 4) return "R3";
        if (m == 5) return "R4";
        return "R5";
    endfunction

    task automatic check(input string req, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: enables actual %b expected %b", req, got, exp);
        end
    endtask

    // drive for one cycle starting at a negedge; returns at the next negedge
    task automatic drive(input logic w, input logic [2:0] d, input logic i, input logic r);
        mode_wr    = w;
        mode_wdata = d;
        irq_pend   = i;
        reti_stb   = r;
        @(negedge clk);
        mode_wr  = 1'b0;
        irq_pend = 1'b0;
        reti_stb = 1'b0;
    endtask

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        rst = 1'b1; mode_wr = 1'b0; mode_wdata = '0; irq_pend = 1'b0; reti_stb = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", 8'hFF);
        rst = 1'b0;
        @(negedge clk);
        check("R1", 8'hFF);
        // R8/R1: no service after reset, so a return changes nothing
        drive(1'b0, 3'd0, 1'b0, 1'b1);
        check("R8", 8'hFF);
        for (int m = 0; m < 8; m++) begin
            drive(1'b1, 3'(m), 1'b0, 1'b0);
            check(req_of(m), expect_en(m));
            drive(1'b0, 3'd0, 1'b0, 1'b0);
            check("R12", expect_en(m));
            drive(1'b0, 3'd0, 1'b0, 1'b1);
            check("R8", expect_en(m));
            drive(1'b0, 3'd0, 1'b1, 1'b0);
            check("R6", 8'hFF);
            drive(1'b0, 3'd0, 1'b1, 1'b0);
            check("R9", 8'hFF);
            drive(1'b0, 3'd0, 1'b0, 1'b1);
            check("R7", expect_en(m));
            for (int w = 0; w < 8; w++) begin
                drive(1'b0, 3'd0, 1'b1, 1'b0);
                check("R6", 8'hFF);
                drive(1'b1, 3'(w), 1'b0, 1'b0);
                check("R10", 8'hFF);
                // return with a competing write: the write is dropped
                drive(1'b1, 3'(w + 3), 1'b0, 1'b1);
                check("R11", expect_en(w));
                // wake with a competing write: the write is dropped
                drive(1'b1, 3'(w + 1), 1'b1, 1'b0);
                check("R11", 8'hFF);
                drive(1'b0, 3'd0, 1'b0, 1'b1);
                check("R7", expect_en(w));
            end
        end
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual running expected done");
            report();
            $finish;
        end
    end

endmodule